// File: doc/BRIEF.md
# Read Window Centre Calculator

Once a read-leveling search has found, for every byte lane, the first and the last passing setting, this block turns each pair into one centred setting. A setting is a coarse phase code plus a fine delay tap. The block forms a linear tap position for both ends of the window and takes the floored midpoint between them. It then splits that midpoint back into a phase and a tap. In full-rate (1:1) mode only the codes 0, 1, 4 and 5 are valid. These codes are packed into the dense range 0..3 before the arithmetic and unpacked afterwards.

The block runs through the lanes one per clock cycle. While it does so it tracks the smallest centre phase seen. In a last cycle it forms the read-ready delay: the sample delay plus a 3-bit adjustment taken from a packed configuration word, at a position chosen by that smallest phase. A one-cycle start pulse begins a run. A one-cycle done pulse ends it. The results then stay on the outputs until the next run.

Top module: `rd_window_centre`

## Requirements
- R1: After reset, busy and done are 0, and every centre phase, centre delay, minPhase and readyDelay output is 0.
- R2: A start pulse seen while idle raises busy on the next cycle. Busy stays high for NUM_LANES+1 cycles. Done is high for exactly the one cycle after busy falls.
- R3: In half-rate (2:1) mode, lane i is computed from two linear positions, S = startPhase*MAX_DELAY + startDelay and E = endPhase*MAX_DELAY + endDelay, with E >= S. The centre is C = S + (E-S)/2, rounded down. The lane's centre phase is C / MAX_DELAY and its centre delay is C % MAX_DELAY. Lane i occupies bits [i*PHASE_W +: PHASE_W] of the phase buses and bits [i*DELAY_W +: DELAY_W] of the delay buses.
- R4: In 1:1 mode (mode1to1=1), a start or end phase above 1 is reduced by 2 before R3's arithmetic. A resulting centre phase above 1 is raised by 2. The centre phase therefore never equals 2 or 3.
- R5: minPhase equals the smallest centre phase over all lanes of the last run. The running minimum starts each run at 10.
- R6: In 1:1 mode, the adjustment is cfgWord[off +: 3], where off is 0, 3, 6 or 9 for minPhase 0, 1, 4 or 5. Any other minPhase uses off = 0.
- R7: In 2:1 mode, the adjustment is cfgWord[minPhase*3 +: 3].
- R8: At done, readyDelay equals sampleDelay plus the selected adjustment, with one bit of headroom.
- R9: A start pulse while busy is ignored. The run's done timing and results are unchanged.
- R10: After done, all outputs hold their values until the next start, even if the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| mode1to1 | input | 1 | 1 = full-rate sparse phase codes, 0 = half-rate |
| startPhase | input | NUM_LANES*PHASE_W | Window start phase per lane |
| startDelay | input | NUM_LANES*DELAY_W | Window start fine delay per lane |
| endPhase | input | NUM_LANES*PHASE_W | Window end phase per lane |
| endDelay | input | NUM_LANES*DELAY_W | Window end fine delay per lane |
| sampleDelay | input | SMPL_W | Read sample delay |
| cfgWord | input | CFG_W | Packed 3-bit adjustment fields |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| centrePhase | output | NUM_LANES*PHASE_W | Centre phase per lane |
| centreDelay | output | NUM_LANES*DELAY_W | Centre fine delay per lane |
| minPhase | output | MIN_W | Smallest centre phase |
| readyDelay | output | SMPL_W+1 | Sample delay plus adjustment |

## Verification
Some properties are checked on every cycle. These are the busy/done handshake (busy falling always coincides with a single done cycle), the bound on readyDelay minus sampleDelay, the fact that a 1:1 minimum never takes a packed code, and the fact that the minimum never keeps its initial value of 10. The arithmetic itself can only be shown by the bench's scenarios, which compare each lane's centre, the minimum and the selected adjustment field against independently computed values. The same holds for ignoring a second start and for holding the outputs after done.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
  typedef struct packed {
    logic clearMin;
    logic writeLane;
    logic finish;
  } rwcStrobe_t;
endpackage

// File: rtl/rwc_ctrl.sv
module rwc_ctrl
  import rwc_pkg::*;
#(
  parameter int NUM_LANES = 4,
  localparam int LIDX_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output rwcStrobe_t        strobe,
  output logic [LIDX_W-1:0] laneSel,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {ST_IDLE, ST_LANE, ST_FINISH} state_t;
  state_t state;
  logic [LIDX_W-1:0] laneIdx;
  logic lastLane;

  assign lastLane = (laneIdx == LIDX_W'(NUM_LANES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      laneIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_LANE;
          laneIdx <= '0;
        end
        ST_LANE: if (lastLane) state <= ST_FINISH;
                 else laneIdx <= laneIdx + 1'b1;
        ST_FINISH: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clearMin  = (state == ST_IDLE) && start;
    strobe.writeLane = (state == ST_LANE);
    strobe.finish    = (state == ST_FINISH);
  end

  assign laneSel = laneIdx;
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/rwc_datapath.sv
module rwc_datapath
  import rwc_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int PHASE_W    = 3,
  parameter int MAX_DELAY  = 32,
  parameter int SMPL_W     = 5,
  parameter int ADJ_W      = 3,
  parameter int ADJ_STRIDE = 3,
  parameter int CFG_W      = 24,
  parameter int MIN_INIT   = 10,
  localparam int DELAY_W = $clog2(MAX_DELAY),
  localparam int LIN_W   = $clog2((2 ** PHASE_W) * MAX_DELAY),
  localparam int MIN_W   = $clog2(MIN_INIT + 1),
  localparam int RDY_W   = SMPL_W + 1,
  localparam int LIDX_W  = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         mode1to1,
  input  rwcStrobe_t                   strobe,
  input  logic [LIDX_W-1:0]            laneSel,
  input  logic [NUM_LANES*PHASE_W-1:0] startPhase,
  input  logic [NUM_LANES*DELAY_W-1:0] startDelay,
  input  logic [NUM_LANES*PHASE_W-1:0] endPhase,
  input  logic [NUM_LANES*DELAY_W-1:0] endDelay,
  input  logic [SMPL_W-1:0]            sampleDelay,
  input  logic [CFG_W-1:0]             cfgWord,
  output logic [NUM_LANES*PHASE_W-1:0] centrePhase,
  output logic [NUM_LANES*DELAY_W-1:0] centreDelay,
  output logic [MIN_W-1:0]             minPhase,
  output logic [RDY_W-1:0]             readyDelay
);
  logic [PHASE_W-1:0] sPh, ePh, sPhC, ePhC, cPhRaw, cPhOut;
  logic [DELAY_W-1:0] sDl, eDl, cDl;
  logic [LIN_W-1:0]   sLin, eLin, mid;
  logic [LIN_W:0]     linSum;
  logic [MIN_W-1:0]   minReg;
  logic [ADJ_W-1:0]   adj;
  int                 adjOff;

  // Lane select and sparse-code packing
  always_comb begin
    sPh  = startPhase[laneSel*PHASE_W +: PHASE_W];
    ePh  = endPhase[laneSel*PHASE_W +: PHASE_W];
    sDl  = startDelay[laneSel*DELAY_W +: DELAY_W];
    eDl  = endDelay[laneSel*DELAY_W +: DELAY_W];
    sPhC = (mode1to1 && sPh > PHASE_W'(1)) ? sPh - PHASE_W'(2) : sPh;
    ePhC = (mode1to1 && ePh > PHASE_W'(1)) ? ePh - PHASE_W'(2) : ePh;
  end

  // Linear midpoint and split back into phase/tap
  always_comb begin
    sLin   = LIN_W'(sPhC) * LIN_W'(MAX_DELAY) + LIN_W'(sDl);
    eLin   = LIN_W'(ePhC) * LIN_W'(MAX_DELAY) + LIN_W'(eDl);
    linSum = {1'b0, sLin} + {1'b0, eLin};
    mid    = LIN_W'(linSum >> 1);
    cPhRaw = PHASE_W'(mid / LIN_W'(MAX_DELAY));
    cDl    = DELAY_W'(mid % LIN_W'(MAX_DELAY));
    cPhOut = (mode1to1 && cPhRaw > PHASE_W'(1)) ? cPhRaw + PHASE_W'(2) : cPhRaw;
  end

  // Adjustment field position chosen by minimum phase
  always_comb begin
    if (mode1to1) begin
      case (minReg)
        MIN_W'(1): adjOff = 3;
        MIN_W'(4): adjOff = 6;
        MIN_W'(5): adjOff = 9;
        default:   adjOff = 0;
      endcase
    end else begin
      adjOff = int'(minReg) * ADJ_STRIDE;
    end
    adj = ADJ_W'(cfgWord >> adjOff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      centrePhase <= '0;
      centreDelay <= '0;
      minReg      <= '0;
      readyDelay  <= '0;
    end else begin
      if (strobe.clearMin) minReg <= MIN_W'(MIN_INIT);
      if (strobe.writeLane) begin
        centrePhase[laneSel*PHASE_W +: PHASE_W] <= cPhOut;
        centreDelay[laneSel*DELAY_W +: DELAY_W] <= cDl;
        if (MIN_W'(cPhOut) < minReg) minReg <= MIN_W'(cPhOut);
      end
      if (strobe.finish) readyDelay <= RDY_W'(sampleDelay) + RDY_W'(adj);
    end
  end

  assign minPhase = minReg;
endmodule

// File: rtl/rd_window_centre.sv
module rd_window_centre
  import rwc_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int PHASE_W    = 3,
  parameter int MAX_DELAY  = 32,
  parameter int SMPL_W     = 5,
  parameter int ADJ_W      = 3,
  parameter int ADJ_STRIDE = 3,
  parameter int CFG_W      = 24,
  parameter int MIN_INIT   = 10,
  localparam int DELAY_W = $clog2(MAX_DELAY),
  localparam int MIN_W   = $clog2(MIN_INIT + 1),
  localparam int RDY_W   = SMPL_W + 1,
  localparam int LIDX_W  = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic                         mode1to1,
  input  logic [NUM_LANES*PHASE_W-1:0] startPhase,
  input  logic [NUM_LANES*DELAY_W-1:0] startDelay,
  input  logic [NUM_LANES*PHASE_W-1:0] endPhase,
  input  logic [NUM_LANES*DELAY_W-1:0] endDelay,
  input  logic [SMPL_W-1:0]            sampleDelay,
  input  logic [CFG_W-1:0]             cfgWord,
  output logic                         busy,
  output logic                         done,
  output logic [NUM_LANES*PHASE_W-1:0] centrePhase,
  output logic [NUM_LANES*DELAY_W-1:0] centreDelay,
  output logic [MIN_W-1:0]             minPhase,
  output logic [RDY_W-1:0]             readyDelay
);
  rwcStrobe_t        strobe;
  logic [LIDX_W-1:0] laneSel;

  rwc_ctrl #(.NUM_LANES(NUM_LANES)) ctrlInst (
    .clk(clk), .rstN(rstN), .start(start),
    .strobe(strobe), .laneSel(laneSel), .busy(busy), .done(done)
  );

  rwc_datapath #(
    .NUM_LANES(NUM_LANES), .PHASE_W(PHASE_W), .MAX_DELAY(MAX_DELAY),
    .SMPL_W(SMPL_W), .ADJ_W(ADJ_W), .ADJ_STRIDE(ADJ_STRIDE),
    .CFG_W(CFG_W), .MIN_INIT(MIN_INIT)
  ) dpInst (
    .clk(clk), .rstN(rstN), .mode1to1(mode1to1),
    .strobe(strobe), .laneSel(laneSel),
    .startPhase(startPhase), .startDelay(startDelay),
    .endPhase(endPhase), .endDelay(endDelay),
    .sampleDelay(sampleDelay), .cfgWord(cfgWord),
    .centrePhase(centrePhase), .centreDelay(centreDelay),
    .minPhase(minPhase), .readyDelay(readyDelay)
  );
endmodule

// File: rtl/rwc_chk.sv
module rwc_chk #(
  parameter int SMPL_W   = 5,
  parameter int ADJ_W    = 3,
  parameter int MIN_INIT = 10,
  localparam int MIN_W = $clog2(MIN_INIT + 1),
  localparam int RDY_W = SMPL_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              mode1to1,
  input logic              busy,
  input logic              done,
  input logic [SMPL_W-1:0] sampleDelay,
  input logic [MIN_W-1:0]  minPhase,
  input logic [RDY_W-1:0]  readyDelay
);
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R2
  AST_DONE_ON_BUSY_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R2
  AST_MIN_UPDATED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (minPhase < MIN_W'(MIN_INIT))); // R5
  AST_MIN_SPARSE: assert property (@(posedge clk) disable iff (!rstN)
    (done && mode1to1) |-> (minPhase != MIN_W'(2) && minPhase != MIN_W'(3))); // R4
  AST_READY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (readyDelay >= RDY_W'(sampleDelay) &&
              readyDelay - RDY_W'(sampleDelay) < RDY_W'(2 ** ADJ_W))); // R8
endmodule

bind rd_window_centre rwc_chk #(
  .SMPL_W(SMPL_W), .ADJ_W(ADJ_W), .MIN_INIT(MIN_INIT)
) chkInst (
  .clk(clk), .rstN(rstN), .start(start), .mode1to1(mode1to1),
  .busy(busy), .done(done), .sampleDelay(sampleDelay),
  .minPhase(minPhase), .readyDelay(readyDelay)
);

// File: tb/tb_rd_window_centre.sv
module tb_rd_window_centre;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4, PW = 3, MD = 32, DW = 5, SW = 5, CW = 24;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, mode1to1 = 1'b0;
  logic [NL*PW-1:0] startPhase = '0, endPhase = '0;
  logic [NL*DW-1:0] startDelay = '0, endDelay = '0;
  logic [SW-1:0] sampleDelay = '0;
  logic [CW-1:0] cfgWord = '0;
  logic busy, done;
  logic [NL*PW-1:0] centrePhase;
  logic [NL*DW-1:0] centreDelay;
  logic [3:0] minPhase;
  logic [SW:0] readyDelay;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_window_centre dut (
    .clk(clk), .rstN(rstN), .start(start), .mode1to1(mode1to1),
    .startPhase(startPhase), .startDelay(startDelay),
    .endPhase(endPhase), .endDelay(endDelay),
    .sampleDelay(sampleDelay), .cfgWord(cfgWord),
    .busy(busy), .done(done), .centrePhase(centrePhase),
    .centreDelay(centreDelay), .minPhase(minPhase), .readyDelay(readyDelay)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int packPh(bit m, int p);
    return (m && p > 1) ? p - 2 : p;
  endfunction

  function automatic int adjOf(bit m, int mn, logic [CW-1:0] cfg);
    int off;
    if (m) begin
      case (mn) 1: off = 3; 4: off = 6; 5: off = 9; default: off = 0; endcase
    end else off = mn * 3;
    return int'((cfg >> off) & 24'd7);
  endfunction

  task automatic runAndCheck(input string tag, input bit restart);
    int cnt = 0, mn = 10, s, e, c, cp, cd;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && cnt < 50) begin
      @(negedge clk); cnt++;
      if (restart && cnt == 2) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    check(cnt == NL + 1, restart ? "R9 done latency" : "R2 done latency", cnt, NL + 1);
    for (int i = 0; i < NL; i++) begin
      s = packPh(mode1to1, int'(startPhase[i*PW +: PW])) * MD + int'(startDelay[i*DW +: DW]);
      e = packPh(mode1to1, int'(endPhase[i*PW +: PW])) * MD + int'(endDelay[i*DW +: DW]);
      c = s + (e - s) / 2;
      cp = c / MD; cd = c % MD;
      if (mode1to1 && cp > 1) cp += 2;
      if (cp < mn) mn = cp;
      check(int'(centrePhase[i*PW +: PW]) == cp, mode1to1 ? "R4 centre phase" : "R3 centre phase",
            int'(centrePhase[i*PW +: PW]), cp);
      check(int'(centreDelay[i*DW +: DW]) == cd, "R3 centre delay", int'(centreDelay[i*DW +: DW]), cd);
    end
    check(int'(minPhase) == mn, "R5 min phase", int'(minPhase), mn);
    check(int'(readyDelay) == int'(sampleDelay) + adjOf(mode1to1, mn, cfgWord),
          mode1to1 ? "R6 R8 ready delay" : "R7 R8 ready delay",
          int'(readyDelay), int'(sampleDelay) + adjOf(mode1to1, mn, cfgWord));
    @(negedge clk);
    check(!done && !busy, "R2 done single cycle", int'(done), 0);
    $display("run %s ok so far: errors=%0d", tag, errors);
  endtask

  task automatic randLanes(input bit m);
    int sp, sd, ep, ed, t;
    for (int i = 0; i < NL; i++) begin
      if (m) begin t = $urandom % 4; sp = (t < 2) ? t : t + 2; t = $urandom % 4; ep = (t < 2) ? t : t + 2; end
      else begin sp = $urandom % 8; ep = $urandom % 8; end
      sd = $urandom % MD; ed = $urandom % MD;
      if (packPh(m, sp) * MD + sd > packPh(m, ep) * MD + ed) begin
        t = sp; sp = ep; ep = t; t = sd; sd = ed; ed = t;
      end
      startPhase[i*PW +: PW] = PW'(sp); endPhase[i*PW +: PW] = PW'(ep);
      startDelay[i*DW +: DW] = DW'(sd); endDelay[i*DW +: DW] = DW'(ed);
    end
  endtask

  task automatic setAll(input int sp, input int sd, input int ep, input int ed);
    for (int i = 0; i < NL; i++) begin
      startPhase[i*PW +: PW] = PW'(sp); endPhase[i*PW +: PW] = PW'(ep);
      startDelay[i*DW +: DW] = DW'(sd); endDelay[i*DW +: DW] = DW'(ed);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NL*PW-1:0] holdPh;
    logic [SW:0] holdRdy;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!busy && !done, "R1 reset handshake", int'(busy), 0);
    check(centrePhase == '0 && centreDelay == '0, "R1 reset centres", int'(centrePhase), 0);
    check(readyDelay == '0 && minPhase == '0, "R1 reset ready/min", int'(readyDelay), 0);
    rstN = 1'b1;
    // directed: 2:1 zero window
    mode1to1 = 1'b0; cfgWord = 24'hFFFFF5; sampleDelay = 5'd3;
    setAll(0, 0, 0, 0); runAndCheck("zero", 1'b0);
    // directed: 2:1 wide window, odd span rounds down
    setAll(0, 0, 7, 31); cfgWord = 24'h123456; sampleDelay = 5'd31; runAndCheck("wide", 1'b0);
    // directed: 1:1 all lanes at code 5 (offset 9)
    mode1to1 = 1'b1; cfgWord = 24'h000E00; setAll(5, 2, 5, 30); runAndCheck("code5", 1'b0);
    // directed: 1:1 window spanning 1..4 lands on code 1 or 4
    cfgWord = 24'h0001C0; setAll(1, 10, 4, 20); runAndCheck("span14", 1'b0);
    // R9: second start during run ignored
    mode1to1 = 1'b0; randLanes(1'b0); cfgWord = 24'($urandom); runAndCheck("restart", 1'b1);
    // R10: outputs hold after done
    holdPh = centrePhase; holdRdy = readyDelay;
    randLanes(1'b0); sampleDelay = ~sampleDelay; cfgWord = ~cfgWord;
    repeat (5) @(negedge clk);
    check(centrePhase == holdPh, "R10 centre held", int'(centrePhase), int'(holdPh));
    check(readyDelay == holdRdy, "R10 ready held", int'(readyDelay), int'(holdRdy));
    // random mix
    for (int r = 0; r < 40; r++) begin
      mode1to1 = r[0];
      randLanes(mode1to1);
      sampleDelay = SW'($urandom);
      cfgWord = CW'($urandom);
      runAndCheck("random", 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule